// File: doc/BRIEF.md
# Two-Stage Fixed-Priority Interrupt Controller

This block merges sixteen interrupt sources into one interrupt line toward a processor. Two eight-line stages are chained: a downstream stage collects its own requests, and its combined output is fed into input 2 of an upstream stage. Input 2 has no external connection. The upstream stage drives the processor's interrupt line. Each stage latches requests, masks them, tracks which lines are being serviced, and resolves the winner by fixed priority. Line 0 has the highest priority and line 7 the lowest.

Software uses a small write/read register port. Through it, software masks individual lines, picks edge or level detection per line, sets a vector base per stage, and steers any of the external source pins onto any request line. It also issues end-of-interrupt commands through the same port. When the processor answers the interrupt with a one-cycle acknowledge pulse, the block moves the winning request into service and returns an 8-bit vector on the next cycle. If the downstream stage wins, the vector comes from that stage. Servicing a downstream request then needs one end-of-interrupt command at each stage.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After synchronous reset, the following hold. `cpu_int` and `vec_valid` are low. Both mask registers (addresses 0 and 1) read 0xFF. Both request registers (addresses 8 and 9) and both in-service registers (addresses 10 and 11) read 0x00. The upstream base (address 4) reads 0x08 and the downstream base (address 5) reads 0x70.
- R2: Among the unmasked pending requests of a stage, the lowest-numbered line wins. The upstream vector is the upstream base register with bits 2:0 replaced by the winning line number.
- R3: A line whose mask bit is 1 does not raise `cpu_int`. Its request bit is still recorded in the request register.
- R4: A line in edge mode (trigger-mode bit 0, at address 2 or 3) records a request on a 0-to-1 transition of its source. The request stays set after the source falls, until that line is acknowledged.
- R5: A line in level mode (trigger-mode bit 1) has a request bit that follows its source one cycle later. Acknowledging it does not clear the request bit.
- R6: The 4-bit source-select register for upstream line i is at address 16+i, and for downstream line i at address 24+i. Each line is driven by `src_in` at the index held in its register. At reset, upstream line i selects source i and downstream line i selects source 8+i.
- R7: Upstream line 2 is driven only by the downstream stage's interrupt output. Its source-select register and trigger-mode bit have no effect, so a pulse on the pin it would select leaves upstream request bit 2 clear.
- R8: When an acknowledge is granted to upstream line 2, the following happen. The downstream winner's in-service bit is set. Upstream in-service bit 2 is set. The vector is the downstream base register with bits 2:0 replaced by the downstream line number.
- R9: Writing to address 6 is an end-of-interrupt command. Data bit 0 = 0 selects the upstream stage and 1 selects the downstream stage. The command clears the lowest-numbered set bit of that stage's in-service register. It takes effect in the same cycle as an acknowledge, where the acknowledge sets a bit and the command clears the previously highest one.
- R10: A pending request whose line number is greater than or equal to the highest-priority in-service line of its stage is held pending and not passed on.
- R11: An acknowledge while `cpu_int` is low produces no `vec_valid` and changes no in-service bit.
- R12: `vec_valid` is high for exactly the one cycle after a granted acknowledge, and `vec_data` holds the vector in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | NSRC (16) | External interrupt source pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| int_ack | input | 1 | Interrupt acknowledge pulse from processor |
| cpu_int | output | 1 | Interrupt request to processor |
| vec_valid | output | 1 | Vector valid, one cycle after a granted acknowledge |
| vec_data | output | 8 | Returned interrupt vector |

## Verification
The case that needs the most care is an acknowledge and an end-of-interrupt write landing in the same clock. It arises when a higher-priority line breaks in while a lower one is still in service. The bench provokes it by first putting line 4 in service and then raising line 3. It then drives `int_ack` and an upstream end-of-interrupt write on the same edge. The expected result is that line 4 leaves service and line 3 enters it, with vector 0x0B. A behavioural reference model, stepped on every clock, also compares `cpu_int` and the vector outputs throughout the run. The same model covers the case where the downstream output and its registered copy at upstream line 2 change in the same edge as a configuration write.

// File: rtl/pic_pkg.sv
// Package: shared constants for the two-stage interrupt controller.
// Assumes eight lines per stage and an 8-bit vector whose low bits carry
// the line number.
package pic_pkg;
    localparam int NLINES    = 8;
    localparam int IDXW      = $clog2(NLINES);
    localparam int DW        = 8;
    localparam int AW        = 5;
    localparam int BASEW     = DW - IDXW;
    localparam int NSRC_DFLT = 16;
    localparam int CASC_LINE = 2;

    localparam logic [NLINES-1:0] CASC_BIT = NLINES'(1) << CASC_LINE;

    // register addresses
    localparam logic [AW-1:0] A_MMASK = 5'd0;
    localparam logic [AW-1:0] A_SMASK = 5'd1;
    localparam logic [AW-1:0] A_MTRIG = 5'd2;
    localparam logic [AW-1:0] A_STRIG = 5'd3;
    localparam logic [AW-1:0] A_MBASE = 5'd4;
    localparam logic [AW-1:0] A_SBASE = 5'd5;
    localparam logic [AW-1:0] A_EOI   = 5'd6;
    localparam logic [AW-1:0] A_MIRR  = 5'd8;
    localparam logic [AW-1:0] A_SIRR  = 5'd9;
    localparam logic [AW-1:0] A_MISR  = 5'd10;
    localparam logic [AW-1:0] A_SISR  = 5'd11;

    // pages of per-line source-select registers (upper address bits)
    localparam logic [AW-IDXW-1:0] PG_MSEL = 2'b10;
    localparam logic [AW-IDXW-1:0] PG_SSEL = 2'b11;

    localparam logic [BASEW-1:0] MBASE_RST = 5'd1;   // vector 0x08
    localparam logic [BASEW-1:0] SBASE_RST = 5'd14;  // vector 0x70
endpackage

// File: rtl/prio_pick.sv
// Module: prio_pick
// Finds the lowest-numbered set bit of a request vector (bit 0 wins).
// Assumes N is a power of two. Purely combinational.
module prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // scan from the weakest line toward line 0 so the strongest overwrites
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_src_sel.sv
// Module: irq_src_sel
// Routes one external source pin to each request line using per-line
// select fields. Assumes NSRC is a power of two so every select is valid.
module irq_src_sel #(
    parameter int NL   = 8,
    parameter int NSRC = 16,
    parameter int SELW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]    src,
    input  logic [NL*SELW-1:0] sel_flat,
    output logic [NL-1:0]      lines
);
    for (genvar i = 0; i < NL; i++) begin : g_line
        // one multiplexer per request line
        assign lines[i] = src[sel_flat[i*SELW +: SELW]];
    end
endmodule

// File: rtl/irq_stage.sv
// Module: irq_stage
// One eight-line priority stage: request latch (edge or level per line),
// in-service register, fixed-priority winner and in-service blocking.
// Assumes ack_take and eoi are single-cycle strobes from the parent.
module irq_stage #(
    parameter int NL = 8,
    parameter int IW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] lines,
    input  logic [NL-1:0] mask,
    input  logic [NL-1:0] level,
    input  logic          ack_take,
    input  logic          eoi,
    output logic [NL-1:0] irr,
    output logic [NL-1:0] isr,
    output logic          int_req,
    output logic [IW-1:0] win_idx
);
    logic [NL-1:0] line_prev;
    logic [NL-1:0] pend;
    logic          pend_hit;
    logic          isr_hit;
    logic [IW-1:0] isr_idx;
    logic          take;
    logic [NL-1:0] win_oh;
    logic [NL-1:0] top_oh;
    logic [NL-1:0] ack_set;
    logic [NL-1:0] eoi_clr;

    assign pend = irr & ~mask;

    prio_pick #(.N(NL), .IW(IW)) u_pend_pick (
        .req (pend),
        .hit (pend_hit),
        .idx (win_idx)
    );

    prio_pick #(.N(NL), .IW(IW)) u_isr_pick (
        .req (isr),
        .hit (isr_hit),
        .idx (isr_idx)
    );

    // decode the acknowledge and end-of-interrupt targets
    always_comb begin
        take    = ack_take & pend_hit;
        win_oh  = NL'(1) << win_idx;
        top_oh  = NL'(1) << isr_idx;
        ack_set = take ? win_oh : '0;
        eoi_clr = (eoi && isr_hit) ? top_oh : '0;
    end

    // request passes on only when it outranks everything in service
    assign int_req = pend_hit && (!isr_hit || (win_idx < isr_idx));

    // remember last line values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) line_prev <= '0;
        else        line_prev <= lines;
    end

    // request latch: level lines follow input, edge lines set on rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
        end else begin
            for (int i = 0; i < NL; i++) begin
                if (level[i]) irr[i] <= lines[i];
                else          irr[i] <= (irr[i] & ~ack_set[i]) | (lines[i] & ~line_prev[i]);
            end
        end
    end

    // in-service register: end-of-interrupt clears, acknowledge sets
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~eoi_clr) | ack_set;
    end
endmodule

// File: rtl/pic_regs.sv
// Module: pic_regs
// Configuration register file: masks, trigger modes, vector bases and
// per-line source selects. Decodes end-of-interrupt commands and provides
// a combinational read mux that also exposes request/in-service state.
module pic_regs
    import pic_pkg::*;
#(
    parameter int NSRC = NSRC_DFLT,
    parameter int SELW = $clog2(NSRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data,
    input  logic [NLINES-1:0]      m_irr,
    input  logic [NLINES-1:0]      s_irr,
    input  logic [NLINES-1:0]      m_isr,
    input  logic [NLINES-1:0]      s_isr,
    output logic [NLINES-1:0]      m_mask,
    output logic [NLINES-1:0]      s_mask,
    output logic [NLINES-1:0]      m_trig,
    output logic [NLINES-1:0]      s_trig,
    output logic [BASEW-1:0]       m_base,
    output logic [BASEW-1:0]       s_base,
    output logic [NLINES*SELW-1:0] m_sel_flat,
    output logic [NLINES*SELW-1:0] s_sel_flat,
    output logic                   eoi_m,
    output logic                   eoi_s
);
    logic [SELW-1:0] m_sel [NLINES];
    logic [SELW-1:0] s_sel [NLINES];

    logic [AW-IDXW-1:0] wr_page;
    logic [IDXW-1:0]    wr_line;
    logic [AW-IDXW-1:0] rd_page;
    logic [IDXW-1:0]    rd_line;

    assign wr_page = wr_addr[AW-1:IDXW];
    assign wr_line = wr_addr[IDXW-1:0];
    assign rd_page = rd_addr[AW-1:IDXW];
    assign rd_line = rd_addr[IDXW-1:0];

    // end-of-interrupt command strobes
    assign eoi_m = wr_en && (wr_addr == A_EOI) && !wr_data[0];
    assign eoi_s = wr_en && (wr_addr == A_EOI) &&  wr_data[0];

    // scalar configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_mask <= '1;
            s_mask <= '1;
            m_trig <= '0;
            s_trig <= '0;
            m_base <= MBASE_RST;
            s_base <= SBASE_RST;
        end else if (wr_en) begin
            case (wr_addr)
                A_MMASK: m_mask <= wr_data;
                A_SMASK: s_mask <= wr_data;
                A_MTRIG: m_trig <= wr_data;
                A_STRIG: s_trig <= wr_data;
                A_MBASE: m_base <= wr_data[DW-1:IDXW];
                A_SBASE: s_base <= wr_data[DW-1:IDXW];
                default: ;
            endcase
        end
    end

    // per-line source select registers
    always_ff @(posedge clk) begin
        for (int i = 0; i < NLINES; i++) begin
            if (!rst_n) begin
                m_sel[i] <= SELW'(i);
                s_sel[i] <= SELW'(NLINES + i);
            end else if (wr_en && (wr_line == IDXW'(i))) begin
                if (wr_page == PG_MSEL) m_sel[i] <= wr_data[SELW-1:0];
                if (wr_page == PG_SSEL) s_sel[i] <= wr_data[SELW-1:0];
            end
        end
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_flat
        assign m_sel_flat[i*SELW +: SELW] = m_sel[i];
        assign s_sel_flat[i*SELW +: SELW] = s_sel[i];
    end

    // read-back multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_MMASK: rd_data = m_mask;
            A_SMASK: rd_data = s_mask;
            A_MTRIG: rd_data = m_trig;
            A_STRIG: rd_data = s_trig;
            A_MBASE: rd_data = {m_base, {IDXW{1'b0}}};
            A_SBASE: rd_data = {s_base, {IDXW{1'b0}}};
            A_MIRR:  rd_data = m_irr;
            A_SIRR:  rd_data = s_irr;
            A_MISR:  rd_data = m_isr;
            A_SISR:  rd_data = s_isr;
            default: begin
                if (rd_page == PG_MSEL) rd_data = DW'(m_sel[rd_line]);
                if (rd_page == PG_SSEL) rd_data = DW'(s_sel[rd_line]);
            end
        endcase
    end
endmodule

// File: rtl/cascade_irq_ctrl.sv
// Module: cascade_irq_ctrl (top)
// Chains a downstream stage into input 2 of an upstream stage. The upstream
// stage drives the processor interrupt line. A granted acknowledge returns
// the winner's vector one cycle later. Assumes int_ack is a one-cycle pulse.
module cascade_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NSRC = NSRC_DFLT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic            int_ack,
    output logic            cpu_int,
    output logic            vec_valid,
    output logic [DW-1:0]   vec_data
);
    localparam int SELW = $clog2(NSRC);

    logic [NLINES-1:0]      m_mask, s_mask, m_trig, s_trig;
    logic [BASEW-1:0]       m_base, s_base;
    logic [NLINES*SELW-1:0] m_sel_flat, s_sel_flat;
    logic                   eoi_m, eoi_s;
    logic [NLINES-1:0]      m_ext, s_lines, m_lines, m_level;
    logic [NLINES-1:0]      m_irr, m_isr, s_irr, s_isr;
    logic                   s_int, m_int;
    logic [IDXW-1:0]        m_win, s_win;
    logic                   ack_ok, slave_won;

    pic_regs #(.NSRC(NSRC), .SELW(SELW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .m_irr      (m_irr),
        .s_irr      (s_irr),
        .m_isr      (m_isr),
        .s_isr      (s_isr),
        .m_mask     (m_mask),
        .s_mask     (s_mask),
        .m_trig     (m_trig),
        .s_trig     (s_trig),
        .m_base     (m_base),
        .s_base     (s_base),
        .m_sel_flat (m_sel_flat),
        .s_sel_flat (s_sel_flat),
        .eoi_m      (eoi_m),
        .eoi_s      (eoi_s)
    );

    irq_src_sel #(.NL(NLINES), .NSRC(NSRC), .SELW(SELW)) u_msel (
        .src      (src_in),
        .sel_flat (m_sel_flat),
        .lines    (m_ext)
    );

    irq_src_sel #(.NL(NLINES), .NSRC(NSRC), .SELW(SELW)) u_ssel (
        .src      (src_in),
        .sel_flat (s_sel_flat),
        .lines    (s_lines)
    );

    // cascade input replaces the external pin and is always level-sensed
    always_comb begin
        m_lines = (m_ext & ~CASC_BIT) | (s_int ? CASC_BIT : '0);
        m_level = m_trig | CASC_BIT;
    end

    // acknowledge is granted only while the interrupt line is up
    assign ack_ok    = int_ack && m_int;
    assign slave_won = ack_ok && (m_win == IDXW'(CASC_LINE));

    irq_stage #(.NL(NLINES), .IW(IDXW)) u_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (s_lines),
        .mask     (s_mask),
        .level    (s_trig),
        .ack_take (slave_won),
        .eoi      (eoi_s),
        .irr      (s_irr),
        .isr      (s_isr),
        .int_req  (s_int),
        .win_idx  (s_win)
    );

    irq_stage #(.NL(NLINES), .IW(IDXW)) u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (m_lines),
        .mask     (m_mask),
        .level    (m_level),
        .ack_take (ack_ok),
        .eoi      (eoi_m),
        .irr      (m_irr),
        .isr      (m_isr),
        .int_req  (m_int),
        .win_idx  (m_win)
    );

    assign cpu_int = m_int;

    // vector register: one-cycle valid after a granted acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_data  <= '0;
        end else begin
            vec_valid <= ack_ok;
            if (ack_ok) vec_data <= slave_won ? {s_base, s_win} : {m_base, m_win};
        end
    end
endmodule

// File: rtl/pic_checker.sv
// Module: pic_checker
// Temporal properties of the controller, attached to the top by bind.
module pic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       int_ack,
    input logic       cpu_int,
    input logic       vec_valid,
    input logic [7:0] m_irr,
    input logic [7:0] m_isr,
    input logic [7:0] m_mask,
    input logic       s_int,
    input logic       eoi_m
);
    p_vec_after_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vec_valid == $past(int_ack && cpu_int)));

    p_no_vec_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(cpu_int));

    p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |-> ((m_irr & ~m_mask) != 8'h00));

    p_line0_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |-> !m_isr[0]);

    p_cascade_feed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (m_irr[2] == $past(s_int)));

    p_one_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(m_isr & ~$past(m_isr)) <= 1);

    p_eoi_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eoi_m) && !$past(int_ack && cpu_int) && ($past(m_isr) != 8'h00))
        |-> (($countones(m_isr) + 1) == $countones($past(m_isr))));
endmodule

bind cascade_irq_ctrl pic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_ack   (int_ack),
    .cpu_int   (cpu_int),
    .vec_valid (vec_valid),
    .m_irr     (m_irr),
    .m_isr     (m_isr),
    .m_mask    (m_mask),
    .s_int     (s_int),
    .eoi_m     (eoi_m)
);

// File: tb/tb_cascade_irq_ctrl.sv
// Bench: directed scenarios plus a behavioural reference model stepped on
// every clock edge and compared at every falling edge.
module tb_cascade_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        int_ack = 1'b0;
    logic        cpu_int;
    logic        vec_valid;
    logic [7:0]  vec_data;

    int checks = 0;
    int errors = 0;
    bit run    = 1'b0;

    always #2.5 clk = ~clk;

    cascade_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .int_ack(int_ack), .cpu_int(cpu_int),
        .vec_valid(vec_valid), .vec_data(vec_data)
    );

    // ---------------- reference model ----------------
    bit [7:0] mm, sm, mt, st, mirr, sirr, misr, sisr, mprev, sprev;
    bit [4:0] mb, sb;
    int       msel [8];
    int       ssel [8];
    bit       mv;
    bit [7:0] mvd;

    function automatic int first(bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic bit sint(bit [7:0] irr, bit [7:0] mask, bit [7:0] isr);
        int w = first(irr & ~mask);
        int t = first(isr);
        return (w < 8) && (w < t);
    endfunction

    always @(posedge clk) begin
        bit s_i, m_i, ack, sack;
        int mw, sw, t;
        bit [7:0] ml, sl, nmi, nsi, nmisr, nsisr;
        if (!rst_n) begin
            mm = 8'hFF; sm = 8'hFF; mt = 0; st = 0;
            mirr = 0; sirr = 0; misr = 0; sisr = 0; mprev = 0; sprev = 0;
            mb = 5'd1; sb = 5'd14; mv = 0; mvd = 0;
            for (int i = 0; i < 8; i++) begin msel[i] = i; ssel[i] = 8 + i; end
        end else begin
            s_i = sint(sirr, sm, sisr);
            m_i = sint(mirr, mm, misr);
            mw  = first(mirr & ~mm);
            sw  = first(sirr & ~sm);
            ack = int_ack && m_i;
            sack = ack && (mw == 2) && (sw < 8);
            for (int i = 0; i < 8; i++) begin
                ml[i] = src_in[msel[i]];
                sl[i] = src_in[ssel[i]];
            end
            ml[2] = s_i;
            mv = ack;
            if (ack) mvd = (mw == 2) ? {sb, 3'(sw)} : {mb, 3'(mw)};
            for (int i = 0; i < 8; i++) begin
                if (mt[i] || i == 2) nmi[i] = ml[i];
                else nmi[i] = (mirr[i] && !(ack && mw == i)) || (ml[i] && !mprev[i]);
                if (st[i]) nsi[i] = sl[i];
                else nsi[i] = (sirr[i] && !(sack && sw == i)) || (sl[i] && !sprev[i]);
            end
            nmisr = misr; nsisr = sisr;
            if (wr_en && wr_addr == 5'd6) begin
                if (!wr_data[0]) begin t = first(misr); if (t < 8) nmisr[t] = 0; end
                else begin t = first(sisr); if (t < 8) nsisr[t] = 0; end
            end
            if (ack) nmisr[mw] = 1;
            if (sack) nsisr[sw] = 1;
            if (wr_en) begin
                case (wr_addr)
                    5'd0: mm = wr_data;
                    5'd1: sm = wr_data;
                    5'd2: mt = wr_data;
                    5'd3: st = wr_data;
                    5'd4: mb = wr_data[7:3];
                    5'd5: sb = wr_data[7:3];
                    default: begin
                        if (wr_addr[4:3] == 2'b10) msel[wr_addr[2:0]] = int'(wr_data[3:0]);
                        if (wr_addr[4:3] == 2'b11) ssel[wr_addr[2:0]] = int'(wr_data[3:0]);
                    end
                endcase
            end
            mirr = nmi; sirr = nsi; misr = nmisr; sisr = nsisr;
            mprev = ml; sprev = sl;
        end
    end

    // per-cycle comparison against the model (R2 line, R12 vector)
    always @(negedge clk) begin
        if (rst_n && run) begin
            checks++;
            if (cpu_int !== sint(mirr, mm, misr)) begin
                errors++;
                $display("FAIL R2 model cpu_int actual=%0b expected=%0b", cpu_int, sint(mirr, mm, misr));
            end
            checks++;
            if (vec_valid !== mv || (mv && vec_data !== mvd)) begin
                errors++;
                $display("FAIL R12 model vector actual=%0b/%02h expected=%0b/%02h", vec_valid, vec_data, mv, mvd);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input int exp, input string tag);
        @(negedge clk); rd_addr = a; #1;
        chk(int'(rd_data), exp, tag);
    endtask

    task automatic rd_bit(input logic [4:0] a, input int b, input int exp, input string tag);
        @(negedge clk); rd_addr = a; #1;
        chk(int'(rd_data[b]), exp, tag);
    endtask

    task automatic pulse(input int k);
        @(negedge clk); src_in[k] = 1;
        @(negedge clk); src_in[k] = 0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_chk(input int exp, input string tag);
        @(negedge clk); int_ack = 1;
        @(negedge clk); int_ack = 0;
        chk(int'(vec_valid), 1, {tag, " R12 valid"});
        chk(int'(vec_data), exp, tag);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- directed scenarios ----------------
    initial begin
        waitc(3);
        rst_n = 1;
        run = 1;
        // R1 reset state
        chk(int'(cpu_int), 0, "R1 cpu_int");
        chk(int'(vec_valid), 0, "R1 vec_valid");
        rd_chk(5'd0, 8'hFF, "R1 master mask");
        rd_chk(5'd1, 8'hFF, "R1 slave mask");
        rd_chk(5'd4, 8'h08, "R1 master base");
        rd_chk(5'd5, 8'h70, "R1 slave base");
        rd_chk(5'd8, 0, "R1 master irr");
        rd_chk(5'd11, 0, "R1 slave isr");

        // R4 edge latch, R2 vector, R9 end-of-interrupt
        wr(5'd0, 8'hF0);
        pulse(3); waitc(2);
        rd_bit(5'd8, 3, 1, "R4 irr held after fall");
        chk(int'(cpu_int), 1, "R4 cpu_int");
        ack_chk(8'h0B, "R2 vector line3");
        rd_bit(5'd8, 3, 0, "R4 irr cleared by ack");
        rd_chk(5'd10, 8'h08, "R2 isr line3");
        wr(5'd6, 8'h00);
        rd_chk(5'd10, 0, "R9 isr cleared");

        // R3 mask holds line 1 but still latches it
        wr(5'd0, 8'hF2);
        pulse(1); waitc(2);
        chk(int'(cpu_int), 0, "R3 masked no int");
        rd_bit(5'd8, 1, 1, "R3 masked latched");

        // R2 priority, R10 blocking
        pulse(0); waitc(2);
        ack_chk(8'h08, "R2 vector line0");
        wr(5'd0, 8'hF0); waitc(1);
        chk(int'(cpu_int), 0, "R10 line1 blocked by line0");
        wr(5'd6, 8'h00); waitc(1);
        chk(int'(cpu_int), 1, "R10 line1 released after R9");
        ack_chk(8'h09, "R2 vector line1");
        wr(5'd6, 8'h00);
        rd_chk(5'd10, 0, "R9 isr empty");

        // R7 the pin behind line 2 has no effect
        pulse(2); waitc(3);
        chk(int'(cpu_int), 0, "R7 no int from pin");
        rd_chk(5'd8, 0, "R7 master irr clear");

        // R6 source steering
        wr(5'd20, 8'd9); wr(5'd0, 8'hE0);
        pulse(4); waitc(2);
        chk(int'(cpu_int), 0, "R6 old source ignored");
        pulse(9); waitc(2);
        chk(int'(cpu_int), 1, "R6 new source int");
        ack_chk(8'h0C, "R6 vector line4");
        wr(5'd6, 8'h00);

        // R8 downstream request through the cascade
        wr(5'd1, 8'hDF);
        pulse(13); waitc(3);
        chk(int'(cpu_int), 1, "R8 cascade int");
        ack_chk(8'h75, "R8 slave vector");
        rd_chk(5'd10, 8'h04, "R8 master isr bit2");
        rd_chk(5'd11, 8'h20, "R8 slave isr bit5");
        wr(5'd6, 8'h01); wr(5'd6, 8'h00);
        rd_chk(5'd11, 0, "R9 slave isr cleared");
        rd_chk(5'd10, 0, "R9 master isr cleared");

        // R5 level line 6
        wr(5'd2, 8'h40); wr(5'd0, 8'hA0);
        @(negedge clk); src_in[6] = 1;
        waitc(2);
        ack_chk(8'h0E, "R5 vector line6");
        rd_bit(5'd8, 6, 1, "R5 level irr kept after ack");
        @(negedge clk); src_in[6] = 0;
        waitc(2);
        rd_bit(5'd8, 6, 0, "R5 level irr follows source");
        wr(5'd6, 8'h00);

        // R11 acknowledge with no interrupt
        chk(int'(cpu_int), 0, "R11 idle");
        @(negedge clk); int_ack = 1;
        @(negedge clk); int_ack = 0;
        chk(int'(vec_valid), 0, "R11 no vector");
        rd_chk(5'd10, 0, "R11 isr unchanged");

        // R9 with acknowledge in the same cycle
        pulse(9); waitc(2);
        ack_chk(8'h0C, "R2 vector line4 again");
        pulse(3); waitc(2);
        chk(int'(cpu_int), 1, "R10 line3 preempts line4");
        @(negedge clk); int_ack = 1; wr_en = 1; wr_addr = 5'd6; wr_data = 8'h00;
        @(negedge clk); int_ack = 0; wr_en = 0;
        chk(int'(vec_data), 8'h0B, "R9 concurrent vector");
        rd_chk(5'd10, 8'h08, "R9 concurrent isr");
        wr(5'd6, 8'h00);
        rd_chk(5'd10, 0, "R9 final isr");

        waitc(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule